// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits between a UART's serial deserializer and the host register interface. Each received character arrives with three tags: parity error, framing error and line break. The block stores the character and its tags in a queue of up to 16 entries. When queueing is switched off, the queue acts as a single holding register. From the stored contents and from two transmit-side inputs, it builds the 8-bit line status word. It also raises a trigger output once the queue holds at least the programmed number of characters.

The host pops characters through a read strobe and samples the line status through a status-read strobe. A control write sets the queue enable and the 2-bit trigger select. The same write can request a receive-queue flush or a transmit-queue flush. Neither flush request is stored. A long break on the line produces a single zero character, however many break-tagged arrivals the deserializer reports.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset, queueing is disabled, the queue is empty, the trigger select is 00, `readData` is 0, and line status bits 0 to 4 and bit 7 are 0.
- R2: Characters are read in arrival order. `readData` shows the oldest held character, or 0 when nothing is held. Line status bit 0 is 1 exactly while at least one character is held. With queueing enabled, the queue holds 16 characters.
- R3: Capacity is 16 entries with queueing enabled and 1 entry with it disabled. A character that arrives when the queue is at capacity, with no pop in the same cycle, is discarded and the held characters are kept. Line status bit 1 then reads 1 until the cycle after a status read. A character that arrives in the same cycle as a pop of a full queue is accepted.
- R4: Line status bits 2, 3 and 4 give the parity, framing and break tags of the oldest held character. They change when that character is popped, and they read 0 when the queue is empty.
- R5: The first break-tagged arrival is stored as 0x00 with its break tag set, whatever its data. Later break-tagged arrivals are ignored, with no store and no overrun. This lasts until an arrival without the break tag.
- R6: With queueing enabled, line status bit 7 becomes 1 when a character carrying any tag is stored. It returns to 0 in the cycle after a status read, unless another tagged character is stored in that same cycle. With queueing disabled, bit 7 is always 0.
- R7: With queueing enabled, `trigReached` is 1 while the held count is at least 1, 4, 8 or 14, for trigger select 00, 01, 10 or 11 respectively. With queueing disabled, it equals line status bit 0.
- R8: Line status bit 5 equals `txQueueEmpty`. Line status bit 6 equals `txQueueEmpty` AND `txShiftEmpty`.
- R9: Two kinds of control write empty the receive queue and clear bit 7: one with `ctrlRxClear` set, and one that changes the queue enable. Any other control write leaves the held characters in place.
- R10: A control write with `ctrlTxClear` set raises `txFlushPulse` for one cycle, starting in the cycle after the write. The flush request is not retained.
- R11: A read strobe while the queue is empty has no effect on `readData`, on the held count or on the line status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a character arrived from the deserializer |
| rxData | input | 8 | Received character |
| rxParityErr | input | 1 | Parity error tag of the arriving character |
| rxFrameErr | input | 1 | Framing error tag of the arriving character |
| rxBreak | input | 1 | Break tag of the arriving character |
| dataRead | input | 1 | Host pops the oldest character |
| readData | output | 8 | Oldest held character, or 0 when empty |
| statusRead | input | 1 | Host reads the line status; clears bits 1 and 7 on the next edge |
| lineStatus | output | 8 | Line status word (bit layout per R2 to R8) |
| ctrlWrite | input | 1 | Control write strobe |
| ctrlFifoEn | input | 1 | Queue enable value of the control write |
| ctrlRxClear | input | 1 | Receive-queue flush request |
| ctrlTxClear | input | 1 | Transmit-queue flush request |
| ctrlTrigSel | input | 2 | Trigger select: 00=1, 01=4, 10=8, 11=14 characters |
| txQueueEmpty | input | 1 | Transmit holding register or transmit queue is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| trigReached | output | 1 | Held count has reached the trigger depth |
| txFlushPulse | output | 1 | One-cycle flush request to the transmit path |

## Verification
The hardest condition to reach is a full queue that is popped and fed in the same cycle. The bench fills all 16 entries and then drives the read strobe and an arrival together. It then drains the queue to confirm that the new character went in last and that no overrun was flagged. A second hard case is the break suppression window, which ends only on an arrival without the break tag. The bench sends repeated break-tagged arrivals, then a normal character, then a fresh break, and checks that exactly two zero characters come out.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes the control sends to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxqStrobeT;

  // One stored character and its tags
  typedef struct packed {
    logic       brk;
    logic       framing;
    logic       parity;
    logic [7:0] data;
  } rxqEntryT;

  // Trigger depth for a 2-bit select, clamped to the storage depth
  function automatic int unsigned trigDepth(input logic [1:0] sel, input int unsigned depth);
    int unsigned d;
    case (sel)
      2'b00:   d = 1;
      2'b01:   d = 4;
      2'b10:   d = 8;
      default: d = 14;
    endcase
    return (d > depth) ? depth : d;
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobeT        strobe,
  input  rxqEntryT         wrEntry,
  output rxqEntryT         headEntry,
  output logic [LVL_W-1:0] level
);

  rxqEntryT         slot [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // One write-enabled register per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == PTR_W'(i))) slot[i] <= wrEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headEntry = (level != '0) ? slot[rdPtr] : '0;

  // R3: storage never exceeds its depth
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop && !strobe.clear) |-> (level < LVL_W'(DEPTH)));

  // R2: pops only happen on a non-empty queue
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (level != '0));

  // R9: a flush leaves the queue empty
  p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (level == '0));

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  input  logic             rxParityErr,
  input  logic             rxFrameErr,
  input  logic             rxBreak,
  input  logic             dataRead,
  input  logic             statusRead,
  input  logic             ctrlWrite,
  input  logic             ctrlFifoEn,
  input  logic             ctrlRxClear,
  input  logic             ctrlTxClear,
  input  logic [1:0]       ctrlTrigSel,
  input  logic             txQueueEmpty,
  input  logic             txShiftEmpty,
  input  logic [LVL_W-1:0] level,
  input  logic [2:0]       headFlags,
  output rxqStrobeT        strobe,
  output rxqEntryT         wrEntry,
  output logic [7:0]       lineStatus,
  output logic             trigReached,
  output logic             txFlushPulse
);

  logic       fifoEn;
  logic [1:0] trigSel;
  logic       overrun;
  logic       errSticky;
  logic       breakActive;

  logic             nonEmpty;
  logic [LVL_W-1:0] capacity;
  logic             full;
  logic             clearNow;
  logic             candidate;
  logic             canTake;
  logic             anyTag;
  logic             lostChar;

  assign nonEmpty  = (level != '0);
  assign capacity  = fifoEn ? LVL_W'(DEPTH) : LVL_W'(1);
  assign full      = (level >= capacity);
  assign clearNow  = ctrlWrite && (ctrlRxClear || (ctrlFifoEn != fifoEn));
  assign candidate = rxValid && !(rxBreak && breakActive);
  assign anyTag    = rxParityErr || rxFrameErr || rxBreak;

  always_comb begin
    strobe.clear = clearNow;
    strobe.pop   = dataRead && nonEmpty && !clearNow;
    canTake      = !full || strobe.pop;
    strobe.push  = candidate && canTake && !clearNow;
    lostChar     = candidate && !canTake && !clearNow;
  end

  always_comb begin
    wrEntry.brk     = rxBreak;
    wrEntry.framing = rxFrameErr;
    wrEntry.parity  = rxParityErr;
    wrEntry.data    = rxBreak ? 8'h00 : rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoEn       <= 1'b0;
      trigSel      <= 2'b00;
      overrun      <= 1'b0;
      errSticky    <= 1'b0;
      breakActive  <= 1'b0;
      txFlushPulse <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        fifoEn  <= ctrlFifoEn;
        trigSel <= ctrlTrigSel;
      end
      txFlushPulse <= ctrlWrite && ctrlTxClear;

      if (rxValid) breakActive <= rxBreak;

      if (lostChar)        overrun <= 1'b1;
      else if (statusRead) overrun <= 1'b0;

      if (strobe.push && fifoEn && anyTag)            errSticky <= 1'b1;
      else if (statusRead || clearNow || !fifoEn)      errSticky <= 1'b0;
    end
  end

  always_comb begin
    lineStatus[0]   = nonEmpty;
    lineStatus[1]   = overrun;
    lineStatus[4:2] = nonEmpty ? headFlags : 3'b000;
    lineStatus[5]   = txQueueEmpty;
    lineStatus[6]   = txQueueEmpty && txShiftEmpty;
    lineStatus[7]   = errSticky && fifoEn;
  end

  assign trigReached = fifoEn ? (level >= LVL_W'(trigDepth(trigSel, DEPTH))) : nonEmpty;

  // R3: a character refused by a full queue raises the overrun bit
  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !(rxBreak && breakActive) && full && !(dataRead && nonEmpty) && !clearNow)
      |=> lineStatus[1]);

  // R5: break-tagged arrivals during an active break never store
  p_break_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak && breakActive) |-> !strobe.push);

  // R6: a status read with no tagged store clears the error summary
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(strobe.push && anyTag)) |=> !lineStatus[7]);

  // R7: the trigger never fires on an empty queue
  p_trig_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    trigReached |-> lineStatus[0]);

  // R10: the flush pulse follows a flush write
  p_flush_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && ctrlTxClear) |=> txFlushPulse);

endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxParityErr,
  input  logic       rxFrameErr,
  input  logic       rxBreak,
  input  logic       dataRead,
  output logic [7:0] readData,
  input  logic       statusRead,
  output logic [7:0] lineStatus,
  input  logic       ctrlWrite,
  input  logic       ctrlFifoEn,
  input  logic       ctrlRxClear,
  input  logic       ctrlTxClear,
  input  logic [1:0] ctrlTrigSel,
  input  logic       txQueueEmpty,
  input  logic       txShiftEmpty,
  output logic       trigReached,
  output logic       txFlushPulse
);

  rxqStrobeT        strobe;
  rxqEntryT         wrEntry;
  rxqEntryT         headEntry;
  logic [LVL_W-1:0] level;

  rxq_datapath #(.DEPTH(DEPTH)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEntry   (wrEntry),
    .headEntry (headEntry),
    .level     (level)
  );

  rxq_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr),
    .rxBreak      (rxBreak),
    .dataRead     (dataRead),
    .statusRead   (statusRead),
    .ctrlWrite    (ctrlWrite),
    .ctrlFifoEn   (ctrlFifoEn),
    .ctrlRxClear  (ctrlRxClear),
    .ctrlTxClear  (ctrlTxClear),
    .ctrlTrigSel  (ctrlTrigSel),
    .txQueueEmpty (txQueueEmpty),
    .txShiftEmpty (txShiftEmpty),
    .level        (level),
    .headFlags    ({headEntry.brk, headEntry.framing, headEntry.parity}),
    .strobe       (strobe),
    .wrEntry      (wrEntry),
    .lineStatus   (lineStatus),
    .trigReached  (trigReached),
    .txFlushPulse (txFlushPulse)
  );

  assign readData = headEntry.data;

endmodule

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxParityErr = 1'b0;
  logic       rxFrameErr = 1'b0;
  logic       rxBreak = 1'b0;
  logic       dataRead = 1'b0;
  logic [7:0] readData;
  logic       statusRead = 1'b0;
  logic [7:0] lineStatus;
  logic       ctrlWrite = 1'b0;
  logic       ctrlFifoEn = 1'b0;
  logic       ctrlRxClear = 1'b0;
  logic       ctrlTxClear = 1'b0;
  logic [1:0] ctrlTrigSel = 2'b00;
  logic       txQueueEmpty = 1'b1;
  logic       txShiftEmpty = 1'b1;
  logic       trigReached;
  logic       txFlushPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_queue dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pushChar(input logic [7:0] d, input logic pe, input logic fe, input logic brk);
    rxValid = 1'b1; rxData = d; rxParityErr = pe; rxFrameErr = fe; rxBreak = brk;
    tick();
    rxValid = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0; rxBreak = 1'b0;
  endtask

  task automatic readChar(input string req, input logic [7:0] exp);
    check(req, readData, exp);
    dataRead = 1'b1;
    tick();
    dataRead = 1'b0;
  endtask

  task automatic readStatus();
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
  endtask

  task automatic writeCtrl(input logic en, input logic rxc, input logic txc, input logic [1:0] trig);
    ctrlWrite = 1'b1; ctrlFifoEn = en; ctrlRxClear = rxc; ctrlTxClear = txc; ctrlTrigSel = trig;
    tick();
    ctrlWrite = 1'b0; ctrlRxClear = 1'b0; ctrlTxClear = 1'b0;
  endtask

  task automatic testReset();
    check("R1 status", lineStatus, 8'h60);
    check("R1 readData", readData, 8'h00);
    check("R1 trigger", {7'd0, trigReached}, 8'h00);
  endtask

  task automatic testTxBits();
    txShiftEmpty = 1'b0; #1;
    check("R8 shift busy", lineStatus, 8'h20);
    txQueueEmpty = 1'b0; txShiftEmpty = 1'b1; #1;
    check("R8 queue busy", lineStatus, 8'h00);
    txQueueEmpty = 1'b1; #1;
    check("R8 idle", lineStatus, 8'h60);
  endtask

  task automatic testHoldingMode();
    pushChar(8'h41, 0, 0, 0);
    check("R7 disabled trigger", {7'd0, trigReached}, 8'h01);
    pushChar(8'h42, 0, 0, 0);
    check("R3 holding overrun", lineStatus, 8'h63);
    readStatus();
    check("R3 overrun cleared", lineStatus, 8'h61);
    readChar("R3 holding kept", 8'h41);
    check("R2 empty after read", lineStatus, 8'h60);
  endtask

  task automatic testQueueFill();
    writeCtrl(1, 0, 0, 2'b01);
    for (int i = 0; i < 16; i++) begin
      pushChar(8'h30 + 8'(i), 0, 0, 0);
      if (i == 2)  check("R7 below 4", {7'd0, trigReached}, 8'h00);
      if (i == 3) begin
        check("R7 at 4", {7'd0, trigReached}, 8'h01);
        writeCtrl(1, 0, 0, 2'b10);
        check("R7 sel 8 not yet", {7'd0, trigReached}, 8'h00);
      end
      if (i == 7) begin
        check("R7 at 8", {7'd0, trigReached}, 8'h01);
        writeCtrl(1, 0, 0, 2'b11);
        check("R7 sel 14 not yet", {7'd0, trigReached}, 8'h00);
      end
      if (i == 13) check("R7 at 14", {7'd0, trigReached}, 8'h01);
    end
    pushChar(8'hEE, 0, 0, 0);
    check("R3 queue overrun", lineStatus, 8'h63);
    readStatus();
    check("R3 overrun read clear", lineStatus, 8'h61);
    for (int i = 0; i < 16; i++) readChar("R2 order", 8'h30 + 8'(i));
    check("R2 drained", lineStatus, 8'h60);
    dataRead = 1'b1; tick(); dataRead = 1'b0;
    check("R11 empty read data", readData, 8'h00);
    check("R11 empty read status", lineStatus, 8'h60);
  endtask

  task automatic testPopPushFull();
    for (int i = 0; i < 16; i++) pushChar(8'h50 + 8'(i), 0, 0, 0);
    rxValid = 1'b1; rxData = 8'hAB; dataRead = 1'b1;
    tick();
    rxValid = 1'b0; dataRead = 1'b0;
    check("R3 pop and push no overrun", lineStatus, 8'h61);
    for (int i = 1; i < 16; i++) readChar("R3 kept order", 8'h50 + 8'(i));
    readChar("R3 new char last", 8'hAB);
    check("R3 drained", lineStatus, 8'h60);
  endtask

  task automatic testHeadFlags();
    pushChar(8'h10, 0, 0, 0);
    pushChar(8'h11, 1, 0, 0);
    pushChar(8'h12, 0, 1, 0);
    check("R6 summary set", lineStatus, 8'hE1);
    readStatus();
    check("R6 summary read clear", lineStatus, 8'h61);
    readChar("R4 clean head", 8'h10);
    check("R4 parity at head", lineStatus, 8'h65);
    readChar("R4 parity char", 8'h11);
    check("R4 framing at head", lineStatus, 8'h69);
    readChar("R4 framing char", 8'h12);
    check("R4 empty no tags", lineStatus, 8'h60);
  endtask

  task automatic testBreak();
    pushChar(8'h55, 0, 0, 1);
    check("R5 break stored", lineStatus, 8'hF1);
    readStatus();
    pushChar(8'h66, 0, 0, 1);
    pushChar(8'h67, 0, 0, 1);
    check("R5 repeats ignored", lineStatus, 8'h71);
    pushChar(8'h77, 0, 0, 0);
    readChar("R5 zero char", 8'h00);
    check("R5 next head clean", lineStatus, 8'h61);
    readChar("R5 normal after break", 8'h77);
    check("R5 only two chars", lineStatus, 8'h60);
    pushChar(8'h33, 0, 0, 1);
    readChar("R5 new break zero", 8'h00);
    check("R6 sticky after drain", lineStatus, 8'hE0);
    readStatus();
    check("R6 cleared", lineStatus, 8'h60);
  endtask

  task automatic testDisabledSummary();
    writeCtrl(0, 0, 0, 2'b00);
    pushChar(8'h44, 1, 0, 0);
    check("R6 disabled no summary", lineStatus, 8'h65);
    readChar("R6 disabled char", 8'h44);
  endtask

  task automatic testRxClear();
    writeCtrl(1, 0, 0, 2'b00);
    pushChar(8'h01, 0, 1, 0);
    pushChar(8'h02, 0, 0, 0);
    check("R9 before flush", lineStatus, 8'hE9);
    writeCtrl(1, 0, 0, 2'b00);
    check("R9 plain write keeps", lineStatus, 8'hE9);
    writeCtrl(1, 1, 0, 2'b00);
    check("R9 flushed", lineStatus, 8'h60);
    check("R9 flushed data", readData, 8'h00);
  endtask

  task automatic testTxFlush();
    writeCtrl(1, 0, 1, 2'b00);
    check("R10 pulse high", {7'd0, txFlushPulse}, 8'h01);
    tick();
    check("R10 pulse one cycle", {7'd0, txFlushPulse}, 8'h00);
    writeCtrl(1, 0, 0, 2'b00);
    check("R10 no pulse", {7'd0, txFlushPulse}, 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testTxBits();
    testHoldingMode();
    testQueueFill();
    testPopPushFull();
    testHeadFlags();
    testBreak();
    testDisabledSummary();
    testRxClear();
    testTxFlush();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule